// File: doc/BRIEF.md
# Five-Pin GPIO Port with Peripheral Override

This block controls a five-pin bidirectional general-purpose I/O port. Software reaches three registers through a small register bus: an output data latch, a direction register and a read-only view of the pin levels. The direction register decides, pin by pin, whether the latch drives the pad or whether the pad is released and tri-stated. Every pin comes out of reset as an input.

Each pin also has its own peripheral override with a select, an output enable and a data bit. While a pin's select is high, that peripheral decides both the pin's direction and its driven value. The stored direction bit stays as it is, so software can read-modify-write the direction register while peripherals own some of the pins. Pin levels pass through a two-flop synchronizer. The synchronized levels feed the port read path and also go back to the peripherals. In the intended pin assignment, pins 0, 3 and 4 carry capture/compare signals, pin 1 carries serial transmit or the synchronous clock, and pin 2 carries serial receive or the synchronous data. The logic is the same for every pin.

Top module: `pinmux_port`

## Requirements
- R1: After reset every direction bit reads 1, the latch reads 0, and with no peripheral selected every pin has padTriEn = 1.
- R2: A write to address 0 (port) or address 1 (latch) loads busWdata[4:0] into the output latch at the clock edge.
- R3: A read of address 1 returns the stored latch value, even when the pin levels differ from it.
- R4: A read of address 0 returns the pin levels on padIn, delayed by a two-flop synchronizer: a level held for two rising edges is visible.
- R5: A read of address 2 returns the direction register. A write to address 2 loads busWdata[4:0] into it.
- R6: With periphSel[i] = 0, padTriEn[i] equals direction bit i, and padOut[i] equals latch bit i.
- R7: With periphSel[i] = 1, padOut[i] equals periphDout[i], and padTriEn[i] equals the inverse of periphOe[i] (1 = released).
- R8: periphOe[i] and periphDout[i] have no effect on pin i while periphSel[i] = 0.
- R9: Peripheral override never changes the direction register as read at address 2.
- R10: busRdata[7:5] always reads 0, and a read of address 3 returns 0.
- R11: A write to address 3 changes neither the latch nor the direction register.
- R12: periphDin carries the same synchronized pin levels that a port read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register address: 0 port, 1 latch, 2 direction, 3 unused |
| busWe | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| periphSel | input | 5 | Per-pin peripheral select |
| periphOe | input | 5 | Per-pin peripheral output enable (1 = drive) |
| periphDout | input | 5 | Per-pin peripheral data to drive |
| periphDin | output | 5 | Synchronized pin levels for peripherals |
| padIn | input | 5 | Pin levels from the pads |
| padOut | output | 5 | Value driven onto each pin |
| padTriEn | output | 5 | Per-pin tri-state enable (1 = released) |

## Verification
The hardest case to reach is a pin on which the peripheral wants the opposite of what the stored registers say. For example, the direction bit is 1 while the peripheral drives, and the latch and the peripheral data disagree. Meanwhile software writes the direction register and reads it back. Random stimulus draws select, enable, data and register writes independently on each pass, so these conflicts occur often. Directed passes then pin down reset, reads of the latch against differing pad levels, and writes to the unused address.

// File: rtl/pinmux_port_pkg.sv
package pinmux_port_pkg;

  typedef enum logic [1:0] {
    ADDR_PORT  = 2'd0,
    ADDR_LATCH = 2'd1,
    ADDR_DIR   = 2'd2,
    ADDR_NONE  = 2'd3
  } portAddr_e;

  typedef struct packed {
    logic wrLatch;
    logic wrDir;
  } portStrobe_t;

endpackage

// File: rtl/pinmux_port_ctrl.sv
module pinmux_port_ctrl
  import pinmux_port_pkg::*;
(
  input  logic [1:0]  busAddr,
  input  logic        busWe,
  output portStrobe_t strobe,
  output portAddr_e   rdSel
);

  always_comb begin
    rdSel          = portAddr_e'(busAddr);
    strobe.wrLatch = 1'b0;
    strobe.wrDir   = 1'b0;
    if (busWe) begin
      unique case (rdSel)
        ADDR_PORT, ADDR_LATCH: strobe.wrLatch = 1'b1;
        ADDR_DIR:              strobe.wrDir   = 1'b1;
        default:               ;
      endcase
    end
  end

endmodule

// File: rtl/pinmux_port_dp.sv
module pinmux_port_dp
  import pinmux_port_pkg::*;
#(
  parameter int PIN_W       = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strobe,
  input  portAddr_e         rdSel,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PIN_W-1:0]  periphSel,
  input  logic [PIN_W-1:0]  periphOe,
  input  logic [PIN_W-1:0]  periphDout,
  input  logic [PIN_W-1:0]  padIn,
  output logic [PIN_W-1:0]  padOut,
  output logic [PIN_W-1:0]  padTriEn,
  output logic [PIN_W-1:0]  latchQ,
  output logic [PIN_W-1:0]  dirQ,
  output logic [PIN_W-1:0]  syncQ
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [PIN_W-1:0] syncChain [SYNC_STAGES];

  // Storage registers: latch resets low, direction resets to all inputs.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      dirQ   <= '1;
    end else begin
      if (strobe.wrLatch) latchQ <= busWdata[PIN_W-1:0];
      if (strobe.wrDir)   dirQ   <= busWdata[PIN_W-1:0];
    end
  end

  // Pad input synchronizer.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < SYNC_STAGES; k++) syncChain[k] <= '0;
    end else begin
      syncChain[0] <= padIn;
      for (int k = 1; k < SYNC_STAGES; k++) syncChain[k] <= syncChain[k-1];
    end
  end

  assign syncQ = syncChain[LAST];

  // Per-pin override: a selected peripheral owns both data and direction.
  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    assign padOut[i]   = periphSel[i] ? periphDout[i] : latchQ[i];
    assign padTriEn[i] = periphSel[i] ? ~periphOe[i]  : dirQ[i];
  end

  always_comb begin
    busRdata = '0;
    unique case (rdSel)
      ADDR_PORT:  busRdata[PIN_W-1:0] = syncQ;
      ADDR_LATCH: busRdata[PIN_W-1:0] = latchQ;
      ADDR_DIR:   busRdata[PIN_W-1:0] = dirQ;
      default:    busRdata = '0;
    endcase
  end

endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
  import pinmux_port_pkg::*;
#(
  parameter int PIN_W       = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PIN_W-1:0]  periphSel,
  input  logic [PIN_W-1:0]  periphOe,
  input  logic [PIN_W-1:0]  periphDout,
  output logic [PIN_W-1:0]  periphDin,
  input  logic [PIN_W-1:0]  padIn,
  output logic [PIN_W-1:0]  padOut,
  output logic [PIN_W-1:0]  padTriEn
);

  portStrobe_t      strobe;
  portAddr_e        rdSel;
  logic [PIN_W-1:0] latchQ;
  logic [PIN_W-1:0] dirQ;
  logic [PIN_W-1:0] syncQ;

  pinmux_port_ctrl i_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  pinmux_port_dp #(
    .PIN_W       (PIN_W),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rdSel      (rdSel),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .periphSel  (periphSel),
    .periphOe   (periphOe),
    .periphDout (periphDout),
    .padIn      (padIn),
    .padOut     (padOut),
    .padTriEn   (padTriEn),
    .latchQ     (latchQ),
    .dirQ       (dirQ),
    .syncQ      (syncQ)
  );

  assign periphDin = syncQ;

endmodule

// File: rtl/pinmux_port_chk.sv
module pinmux_port_chk #(
  parameter int PIN_W  = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [PIN_W-1:0]  periphSel,
  input logic [PIN_W-1:0]  periphDout,
  input logic [PIN_W-1:0]  padOut,
  input logic [PIN_W-1:0]  latchQ,
  input logic [PIN_W-1:0]  dirQ
);

  // R2: port or latch address write loads the latch
  p_latch_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && (busAddr == 2'd0 || busAddr == 2'd1)) |=> latchQ == $past(busWdata[PIN_W-1:0]));

  // R9: direction register moves only on its own write
  p_dir_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busAddr == 2'd2) |=> $stable(dirQ));

  // R11: write to the unused address leaves both registers alone
  p_none_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 2'd3) |=> ($stable(latchQ) && $stable(dirQ)));

  // R10: upper read bits stay zero
  p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:PIN_W] == '0);

  // R7: selected pins carry peripheral data
  p_sel_data_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((padOut ^ periphDout) & periphSel) == '0);

  // R6: unselected pins carry latch data
  p_unsel_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((padOut ^ latchQ) & ~periphSel) == '0);

endmodule

bind pinmux_port pinmux_port_chk #(.PIN_W(PIN_W), .DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWe      (busWe),
  .busWdata   (busWdata),
  .busRdata   (busRdata),
  .periphSel  (periphSel),
  .periphDout (periphDout),
  .padOut     (padOut),
  .latchQ     (latchQ),
  .dirQ       (dirQ)
);

// File: tb/test_pinmux_port.sv
`timescale 1ns/1ps
module test_pinmux_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [4:0] periphSel = '0, periphOe = '0, periphDout = '0, periphDin;
  logic [4:0] padIn = '0, padOut, padTriEn;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [4:0] mLatch, mDir;

  always #4 clk = ~clk;

  pinmux_port i_pinmux_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .periphSel(periphSel),
    .periphOe(periphOe), .periphDout(periphDout), .periphDin(periphDin),
    .padIn(padIn), .padOut(padOut), .padTriEn(padTriEn)
  );

  function automatic logic [4:0] expOut(logic [4:0] sel, logic [4:0] dout, logic [4:0] lat);
    return (sel & dout) | (~sel & lat);
  endfunction

  function automatic logic [4:0] expTri(logic [4:0] sel, logic [4:0] oe, logic [4:0] dir);
    return (sel & ~oe) | (~sel & dir);
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic readReg(logic [1:0] a, output logic [7:0] v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic writeReg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk);
    if (a == 2'd0 || a == 2'd1) mLatch = d[4:0];
    else if (a == 2'd2) mDir = d[4:0];
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic checkPins(string tag);
    check({tag, " padOut"}, {3'b0, padOut}, {3'b0, expOut(periphSel, periphDout, mLatch)});
    check({tag, " padTriEn"}, {3'b0, padTriEn}, {3'b0, expTri(periphSel, periphOe, mDir)});
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed_1234));
    mLatch = 5'h00;
    mDir   = 5'h1f;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    readReg(2'd2, v); check("R1 dir reset", v, 8'h1f);
    readReg(2'd1, v); check("R1 latch reset", v, 8'h00);
    check("R1 tri reset", {3'b0, padTriEn}, 8'h1f);

    // R2 via port address, R3 latch read with different pad levels
    writeReg(2'd0, 8'hea);
    padIn = 5'h15;
    @(posedge clk); @(posedge clk); @(negedge clk);
    readReg(2'd1, v); check("R2 R3 latch via port addr", v, 8'h0a);
    readReg(2'd0, v); check("R4 port read", v, 8'h15);
    check("R12 periphDin", {3'b0, periphDin}, 8'h15);

    // R5 direction write, R6 drive path
    writeReg(2'd2, 8'hf3);
    readReg(2'd2, v); check("R5 dir read", v, 8'h13);
    checkPins("R6 unselected");

    // R8: oe and dout toggled without select
    periphOe = 5'h1f; periphDout = 5'h15; #1;
    checkPins("R8 unselected ignore");

    // R7 and R9: full override, dir unchanged
    periphSel = 5'h1f; periphOe = 5'h0c; #1;
    checkPins("R7 selected");
    @(posedge clk); @(negedge clk);
    readReg(2'd2, v); check("R9 dir untouched", v, 8'h13);

    // R11: unused address write
    writeReg(2'd3, 8'hff);
    readReg(2'd1, v); check("R11 latch kept", v, {3'b0, mLatch});
    readReg(2'd2, v); check("R11 dir kept", v, {3'b0, mDir});
    // R10
    readReg(2'd3, v); check("R10 unused read", v, 8'h00);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      logic [1:0] a;
      logic [7:0] d;
      logic       we;
      @(negedge clk);
      a = 2'($urandom_range(0, 3));
      d = 8'($urandom);
      we = 1'($urandom_range(0, 1));
      busAddr = a; busWdata = d; busWe = we;
      periphSel = 5'($urandom); periphOe = 5'($urandom);
      periphDout = 5'($urandom); padIn = 5'($urandom);
      @(posedge clk);
      if (we) begin
        if (a == 2'd0 || a == 2'd1) mLatch = d[4:0];
        else if (a == 2'd2) mDir = d[4:0];
      end
      @(negedge clk);
      busWe = 1'b0;
      checkPins("R6 R7 random");
      @(posedge clk); @(negedge clk);
      readReg(2'd0, v); check("R4 random port", v, {3'b0, padIn});
      check("R12 random din", {3'b0, periphDin}, {3'b0, padIn});
      readReg(2'd1, v); check("R2 R3 random latch", v, {3'b0, mLatch});
      readReg(2'd2, v); check("R5 R9 random dir", v, {3'b0, mDir});
      readReg(2'd3, v); check("R10 random unused", v, 8'h00);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule